// File: doc/BRIEF.md
# Tick-Scoped Output Signal Register

This block owns the twelve single-bit output signal lines of a reactive processor core. The core issues two kinds of set commands, each with a 12-bit mask, so that one command can raise any number of lines at once. An emit makes the chosen lines high for the remainder of the current logical tick. A sustain keeps the chosen lines high over any number of ticks. Because a logical tick has no fixed length in clock cycles, the block never times anything itself. It clears emitted lines only when the core pulses a tick-end strobe.

Each sustained line remembers the nesting level of the preemption scope that set it. Level 0 means the line was set outside every scope. When the preemption controller aborts a scope, it pulses a clear with that scope's level. Every sustained line tagged at that level or deeper then drops, and shallower lines stay. The lines come out as an 8-line group and a 4-line group.

Top module: `tick_sig_out`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all twelve output lines are low.
- R2: An emit with mask M raises every line whose mask bit is set, visible from the clock edge that samples the command, and ORs into lines already emitted in the same tick.
- R3: A tick-end strobe with no emit in the same cycle drops every line held only by emit, all together at the same edge.
- R4: An emit in the same cycle as a tick-end strobe belongs to the new tick: after that edge, the emitted lines equal exactly that emit's mask.
- R5: A sustain with mask M raises the masked lines from the sampling edge, and tick-end strobes do not lower them.
- R6: A line sustained at scope level 0 is never lowered by any clear.
- R7: A clear for level k (1 to 4) lowers every sustained line tagged k or deeper, keeps lines tagged shallower, and leaves emitted lines alone. A clear for level 0 has no effect.
- R8: Sustaining a line that is already sustained keeps the shallower (numerically smaller) of the old and new levels.
- R9: When a clear and a sustain arrive in the same cycle, the clear acts on the state before the edge, and the sustain is then applied on top. A line named by the sustain is therefore high afterwards and carries the new level.
- R10: Level inputs greater than 4, on both sustain and clear, are treated as level 4.
- R11: Mask bit i drives output line i: bits 0 to 7 drive `sig_a_o[7:0]` and bits 8 to 11 drive `sig_b_o[3:0]`. Each line is high when it is emitted or sustained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_end_i | input | 1 | One-cycle strobe marking the logical tick boundary |
| emit_en_i | input | 1 | Emit command valid |
| emit_mask_i | input | 12 | Lines to raise for the current tick |
| sus_en_i | input | 1 | Sustain command valid |
| sus_mask_i | input | 12 | Lines to hold across ticks |
| sus_lvl_i | input | 3 | Scope level of the sustain (0 = global) |
| clr_en_i | input | 1 | Scope clear valid |
| clr_lvl_i | input | 3 | Level of the aborted scope |
| sig_a_o | output | 8 | Output lines 0 to 7 |
| sig_b_o | output | 4 | Output lines 8 to 11 |

## Verification
Every command is captured at one clock edge and shows on the output lines right after that edge. No result needs more than one cycle. The bench applies each command at a falling edge and compares the lines at the next falling edge against a model that has been stepped once for that command. In this way a missing or an extra register stage shows up at once. Same-cycle combinations are driven on purpose and are also reached by random traffic: tick with emit, clear with sustain, and re-sustain at another level.

// File: rtl/tso_pkg.sv
package tso_pkg;
  // default geometry of the output signal register
  localparam int DEF_NSIG    = 12;
  localparam int DEF_GRP_A   = 8;
  localparam int DEF_MAX_LVL = 4;

  function automatic int lvl_bits(input int max_lvl);
    int w;
    w = 1;
    while ((1 << w) <= max_lvl) w++;
    return w;
  endfunction
endpackage

// File: rtl/tso_emit_bank.sv
module tso_emit_bank #(
  parameter int NSIG = tso_pkg::DEF_NSIG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_end_i,
  input  logic            emit_en_i,
  input  logic [NSIG-1:0] emit_mask_i,
  output logic [NSIG-1:0] emit_q_o
);
  logic [NSIG-1:0] emit_q, emit_d;
  logic            emit_ld;

  // tick boundary wipes the bank; a same-cycle emit lands in the new tick
  always_comb begin
    emit_d = tick_end_i ? '0 : emit_q;
    if (emit_en_i) emit_d = emit_d | emit_mask_i;
  end

  assign emit_ld = tick_end_i | emit_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       emit_q <= '0;
    else if (emit_ld) emit_q <= emit_d;
  end

  assign emit_q_o = emit_q;

  a_r3_tick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_end_i && !emit_en_i) |=> (emit_q == '0));

  a_r2_emit_visible: assert property (@(posedge clk) disable iff (!rst_n)
    emit_en_i |=> ((emit_q & $past(emit_mask_i)) == $past(emit_mask_i)));

  a_r4_new_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_end_i && emit_en_i) |=> (emit_q == $past(emit_mask_i)));
endmodule

// File: rtl/tso_sus_cell.sv
module tso_sus_cell #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [LVL_W-1:0] set_lvl_i,
  input  logic             clr_en_i,
  input  logic [LVL_W-1:0] clr_lvl_i,
  output logic             held_o
);
  logic             held_q, held_d;
  logic [LVL_W-1:0] tag_q, tag_d;
  logic             clr_hit;
  logic             cell_ld;

  // level 0 is the global scope and is never aborted
  assign clr_hit = clr_en_i && (clr_lvl_i != '0) && held_q && (tag_q >= clr_lvl_i);

  always_comb begin
    held_d = held_q & ~clr_hit;
    tag_d  = tag_q;
    if (set_i) begin
      if (held_d && (tag_q < set_lvl_i)) tag_d = tag_q;
      else                               tag_d = set_lvl_i;
      held_d = 1'b1;
    end
  end

  assign cell_ld = set_i | clr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      tag_q  <= '0;
    end else if (cell_ld) begin
      held_q <= held_d;
      tag_q  <= tag_d;
    end
  end

  assign held_o = held_q;

  a_r6_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && (tag_q == '0)) |=> held_q);

  a_r7_scope_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && (clr_lvl_i != '0) && held_q && (tag_q >= clr_lvl_i) && !set_i) |=> !held_q);

  a_r8_keep_shallow: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && set_i && !clr_en_i) |=> (held_q && (tag_q <= $past(tag_q))));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> held_q);
endmodule

// File: rtl/tick_sig_out.sv
module tick_sig_out #(
  parameter int NSIG    = tso_pkg::DEF_NSIG,
  parameter int GRP_A   = tso_pkg::DEF_GRP_A,
  parameter int MAX_LVL = tso_pkg::DEF_MAX_LVL,
  parameter int LVL_W   = tso_pkg::lvl_bits(MAX_LVL)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_end_i,
  input  logic                  emit_en_i,
  input  logic [NSIG-1:0]       emit_mask_i,
  input  logic                  sus_en_i,
  input  logic [NSIG-1:0]       sus_mask_i,
  input  logic [LVL_W-1:0]      sus_lvl_i,
  input  logic                  clr_en_i,
  input  logic [LVL_W-1:0]      clr_lvl_i,
  output logic [GRP_A-1:0]      sig_a_o,
  output logic [NSIG-GRP_A-1:0] sig_b_o
);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(MAX_LVL);

  logic [LVL_W-1:0] sus_lvl_sat, clr_lvl_sat;
  logic [NSIG-1:0]  emit_q, held_v, line_v;

  // out-of-range scope levels collapse onto the deepest level
  assign sus_lvl_sat = (sus_lvl_i > LVL_TOP) ? LVL_TOP : sus_lvl_i;
  assign clr_lvl_sat = (clr_lvl_i > LVL_TOP) ? LVL_TOP : clr_lvl_i;

  tso_emit_bank #(.NSIG(NSIG)) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_end_i  (tick_end_i),
    .emit_en_i   (emit_en_i),
    .emit_mask_i (emit_mask_i),
    .emit_q_o    (emit_q)
  );

  for (genvar gi = 0; gi < NSIG; gi++) begin : g_sus
    tso_sus_cell #(.LVL_W(LVL_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (sus_en_i && sus_mask_i[gi]),
      .set_lvl_i (sus_lvl_sat),
      .clr_en_i  (clr_en_i),
      .clr_lvl_i (clr_lvl_sat),
      .held_o    (held_v[gi])
    );
  end

  assign line_v  = emit_q | held_v;
  assign sig_a_o = line_v[GRP_A-1:0];
  assign sig_b_o = line_v[NSIG-1:GRP_A];

  a_r5_tick_keeps_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_end_i && !clr_en_i) |=> ((held_v & $past(held_v)) == $past(held_v)));

  a_r7_emit_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && !tick_end_i) |=> ((emit_q & $past(emit_q)) == $past(emit_q)));
endmodule

// File: tb/tick_sig_out_bench.sv
`timescale 1ns/1ps
module tick_sig_out_bench;
  localparam int NS = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_end_i, emit_en_i, sus_en_i, clr_en_i;
  logic [NS-1:0] emit_mask_i, sus_mask_i;
  logic [2:0]    sus_lvl_i, clr_lvl_i;
  logic [7:0]    sig_a_o;
  logic [3:0]    sig_b_o;

  int checks = 0;
  int errors = 0;

  logic [NS-1:0] m_emit, m_held;
  int            m_tag [NS];

  always #10 clk = ~clk;

  tick_sig_out u_tick_sig_out (
    .clk(clk), .rst_n(rst_n), .tick_end_i(tick_end_i),
    .emit_en_i(emit_en_i), .emit_mask_i(emit_mask_i),
    .sus_en_i(sus_en_i), .sus_mask_i(sus_mask_i), .sus_lvl_i(sus_lvl_i),
    .clr_en_i(clr_en_i), .clr_lvl_i(clr_lvl_i),
    .sig_a_o(sig_a_o), .sig_b_o(sig_b_o)
  );

  function automatic int clampl(input int v);
    return (v > 4) ? 4 : v;
  endfunction

  task automatic model_step(input logic t, input logic ee, input logic [NS-1:0] em,
                            input logic se, input logic [NS-1:0] sm, input int sl,
                            input logic ce, input int cl);
    int sls, cls;
    sls = clampl(sl);
    cls = clampl(cl);
    for (int i = 0; i < NS; i++) begin
      logic nh;
      nh = m_held[i];
      if (ce && cls != 0 && m_held[i] && m_tag[i] >= cls) nh = 1'b0;
      if (se && sm[i]) begin
        if (nh) m_tag[i] = (m_tag[i] < sls) ? m_tag[i] : sls;
        else    m_tag[i] = sls;
        nh = 1'b1;
      end
      m_held[i] = nh;
    end
    if (t) m_emit = '0;
    if (ee) m_emit = m_emit | em;
  endtask

  task automatic chk(input string req, input logic [NS-1:0] exp);
    logic [NS-1:0] act;
    act = {sig_b_o, sig_a_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lines got %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; result checked at the next falling edge
  task automatic cyc(input string req, input logic t, input logic ee, input logic [NS-1:0] em,
                     input logic se, input logic [NS-1:0] sm, input int sl,
                     input logic ce, input int cl);
    tick_end_i = t; emit_en_i = ee; emit_mask_i = em;
    sus_en_i = se; sus_mask_i = sm; sus_lvl_i = 3'(sl);
    clr_en_i = ce; clr_lvl_i = 3'(cl);
    model_step(t, ee, em, se, sm, sl, ce, cl);
    @(negedge clk);
    chk(req, m_emit | m_held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick_end_i = 0; emit_en_i = 0; sus_en_i = 0; clr_en_i = 0;
    emit_mask_i = '0; sus_mask_i = '0; sus_lvl_i = '0; clr_lvl_i = '0;
    m_emit = '0; m_held = '0;
    for (int i = 0; i < NS; i++) m_tag[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 12'h000);

    // emit, multi-bit and accumulating
    cyc("R2 multi emit", 0, 1, 12'h0A5, 0, 0, 0, 0, 0);
    chk("R2 literal", 12'h0A5);
    cyc("R2 accumulate", 0, 1, 12'h900, 0, 0, 0, 0, 0);
    checks++;
    if (sig_b_o !== 4'h9 || sig_a_o !== 8'hA5) begin
      errors++;
      $display("FAIL R11: groups got %h/%h expected 9/a5", sig_b_o, sig_a_o);
    end
    cyc("R3 tick clears", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 literal", 12'h000);
    cyc("R2 emit", 0, 1, 12'h003, 0, 0, 0, 0, 0);
    cyc("R4 emit at tick", 1, 1, 12'h030, 0, 0, 0, 0, 0);
    chk("R4 literal", 12'h030);
    cyc("R3 tick", 1, 0, 0, 0, 0, 0, 0, 0);

    // sustain at several levels
    cyc("R5 sus l0", 0, 0, 0, 1, 12'h100, 0, 0, 0);
    cyc("R5 sus l2", 0, 0, 0, 1, 12'h00F, 2, 0, 0);
    cyc("R5 sus l3", 0, 0, 0, 1, 12'h0F0, 3, 0, 0);
    cyc("R5 across tick", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 literal", 12'h1FF);
    cyc("R7 clear l3", 0, 0, 0, 0, 0, 0, 1, 3);
    chk("R7 literal", 12'h10F);
    cyc("R7 clear l0 no effect", 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7 l0 literal", 12'h10F);
    cyc("R7 emit survives clear", 0, 1, 12'h800, 0, 0, 0, 0, 0);
    cyc("R6 clear l1 keeps global", 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R6 literal", 12'h900);
    cyc("R3 tick", 1, 0, 0, 0, 0, 0, 0, 0);

    // re-sustain keeps shallower level
    cyc("R8 sus l1", 0, 0, 0, 1, 12'h002, 1, 0, 0);
    cyc("R8 resus l3", 0, 0, 0, 1, 12'h002, 3, 0, 0);
    cyc("R8 clear l2", 0, 0, 0, 0, 0, 0, 1, 2);
    chk("R8 literal", 12'h102);
    cyc("R8 clear l1", 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R8 l1 literal", 12'h100);

    // same-cycle clear and sustain
    cyc("R9 sus l2", 0, 0, 0, 1, 12'h040, 2, 0, 0);
    cyc("R9 clear+sus", 0, 0, 0, 1, 12'h040, 2, 1, 2);
    chk("R9 literal", 12'h140);
    cyc("R9 clear later", 0, 0, 0, 0, 0, 0, 1, 2);
    chk("R9 later literal", 12'h100);

    // level saturation
    cyc("R10 sus l7", 0, 0, 0, 1, 12'h400, 7, 0, 0);
    cyc("R10 clear l4", 0, 0, 0, 0, 0, 0, 1, 4);
    chk("R10 literal", 12'h100);
    cyc("R10 sus l6", 0, 0, 0, 1, 12'h400, 6, 0, 0);
    cyc("R10 clear l5", 0, 0, 0, 0, 0, 0, 1, 5);
    chk("R10 l5 literal", 12'h100);

    // constrained random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic t, ee, se, ce;
      t  = ($urandom_range(0, 3) == 0);
      ee = ($urandom_range(0, 9) < 4);
      se = ($urandom_range(0, 9) < 2);
      ce = ($urandom_range(0, 9) == 0);
      cyc("R2/R3/R5/R7 random", t, ee, 12'($urandom), se, 12'($urandom & $urandom),
          int'($urandom_range(0, 7)), ce, int'($urandom_range(0, 7)));
    end
    cyc("R1 idle", 0, 0, 0, 0, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule